// File: doc/BRIEF.md
# Coherence Probe Inbox with Barrier Drain

This block is the incoming coherence path of one processor node. It sits in front of a small direct-mapped private data cache. Invalidation probes from the interconnect go into a first-in first-out probe queue. Each probe is acknowledged as soon as the queue accepts it, not when the invalidation reaches the cache. Read replies from the interconnect do not pass through that queue. They are written into the cache at once, so a reply can overtake invalidations that are still waiting.

The core reads the cache through a load port. Until a queued invalidation is applied, the line keeps its old value and still hits. A core memory barrier makes the queue drain, one probe per cycle, until every probe that was queued before the barrier was accepted has been applied. The barrier then reports completion. Without a barrier, probes drain in the background. A background drain happens only in a cycle with no fill and no load, and only after a programmable number of idle cycles has passed since the previous drain.

Top module: `coh_probe_inbox`

## Requirements
- R1: A probe is accepted on a cycle with `prb_valid` high and `prb_ready` high, and `prb_ack` pulses in the following cycle. When QDEPTH probes are waiting, `prb_ready` is low, and an offered probe is neither accepted nor acknowledged.
- R2: A reply is always accepted. It makes its line valid, with the reply's tag and data, by the next cycle, even while invalidations wait in the queue.
- R3: A load to a line that has a queued but unapplied invalidation returns a hit with the old data.
- R4: Probes are applied to the cache in arrival order, at most one per cycle.
- R5: A background drain happens only when no load and no reply is offered in that cycle, and at least DRAIN_GAP cycles after the previous drain.
- R6: A barrier request is accepted when no barrier is in progress. With P probes queued at acceptance, all P are applied on the next P cycles, and `bar_done` is high for exactly one cycle, P+1 cycles after acceptance.
- R7: Probes that arrive after a barrier has been accepted do not delay its `bar_done`, and the barrier does not force them out.
- R8: An applied invalidation whose tag differs from the resident tag of its line leaves the line unchanged.
- R9: When a reply and an applied invalidation address the same line in one cycle, the fill is applied first. If the invalidation's tag equals the filled tag the line ends invalid; otherwise it holds the filled data.
- R10: After reset the queue is empty, `prb_ready` is high, `prb_ack` and `bar_done` are low, and every line is invalid.

An address splits into its low log2(LINES) bits as the line index and the remaining high bits as the tag. A load returns its result (`ld_rsp_valid`, `ld_hit`, `ld_data`) one cycle after `ld_valid`. The result reflects the cache contents before that cycle's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prb_valid | input | 1 | Invalidation probe offered |
| prb_addr | input | AW | Line address to invalidate |
| prb_ready | output | 1 | Probe queue has space |
| prb_ack | output | 1 | Acknowledge for the probe accepted in the previous cycle |
| rpl_valid | input | 1 | Read reply with data present |
| rpl_addr | input | AW | Reply line address |
| rpl_data | input | DW | Reply data |
| ld_valid | input | 1 | Core load request |
| ld_addr | input | AW | Core load address |
| ld_rsp_valid | output | 1 | Load result valid |
| ld_hit | output | 1 | Load hit a valid line with matching tag |
| ld_data | output | DW | Data of the hit line |
| bar_req | input | 1 | Memory-barrier request |
| bar_done | output | 1 | One-cycle pulse when the barrier's probes are applied |

## Verification
The assertions check on every cycle that probe acceptance and acknowledge line up, and that the queue neither overflows nor underflows. They also check that a background drain never uses the port in a cycle with a load or a fill, that a barrier's pending count never exceeds the queue occupancy, and that `bar_done` is a single-cycle pulse. Two cache rules are checked at the moment they occur: an invalidation with a foreign tag leaves its line untouched, and a fill that meets a matching invalidation ends invalid. Only the bench scenarios can show the rest, which concerns visible order over time. These are stale hits while an invalidation waits, replies overtaking the queue, and the order in which probes are applied. They also include the exact completion cycle of a barrier, probes that arrive late, and the background drain after the gap expires.

// File: rtl/coh_probe_pkg.sv
package coh_probe_pkg;

    typedef enum logic [0:0] {
        BAR_IDLE = 1'b0,
        BAR_WAIT = 1'b1
    } bar_state_e;

    // next index of a circular pointer with an arbitrary depth
    function automatic int unsigned ring_next(input int unsigned ptr, input int unsigned depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/coh_probe_fifo.sv
module coh_probe_fifo #(
    parameter int AW    = 16,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    import coh_probe_pkg::*;

    logic [AW-1:0] slot_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CW'(DEPTH));
    assign count     = cnt_q;
    assign head_addr = slot_q[rd_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                slot_q[wr_q] <= push_addr;
                wr_q <= PW'(ring_next(int'(wr_q), DEPTH));
            end
            if (pop) rd_q <= PW'(ring_next(int'(rd_q), DEPTH));
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        empty |-> !pop);

endmodule

// File: rtl/coh_line_store.sv
module coh_line_store #(
    parameter int LINES  = 16,
    parameter int TAG_W  = 12,
    parameter int DW     = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [DW-1:0]    rsp_data,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [DW-1:0]    fill_data,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic [TAG_W-1:0] inv_tag
);
    logic [LINES-1:0] valid_q, valid_d;
    logic [TAG_W-1:0] tag_q  [LINES];
    logic [TAG_W-1:0] tag_d  [LINES];
    logic [DW-1:0]    data_q [LINES];
    logic [DW-1:0]    data_d [LINES];

    // fill first, then the invalidate compares against the post-fill tag
    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            logic fill_here;
            fill_here  = fill_en && (fill_idx == IDX_W'(i));
            tag_d[i]   = fill_here ? fill_tag  : tag_q[i];
            data_d[i]  = fill_here ? fill_data : data_q[i];
            valid_d[i] = fill_here ? 1'b1      : valid_q[i];
            if (inv_en && (inv_idx == IDX_W'(i)) && (inv_tag == tag_d[i]))
                valid_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            valid_q   <= valid_d;
            rsp_valid <= rd_en;
            rsp_hit   <= rd_en && valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
            rsp_data  <= data_q[rd_idx];
        end
        for (int i = 0; i < LINES; i++) begin
            tag_q[i]  <= tag_d[i];
            data_q[i] <= data_d[i];
        end
    end

    // R9: a fill meeting a matching invalidate in one cycle ends invalid
    assert_fill_then_kill_R9: assert property (@(posedge clk) disable iff (rst)
        (fill_en && inv_en && fill_idx == inv_idx && fill_tag == inv_tag)
        |=> !valid_q[$past(inv_idx)]);
    // R8: a foreign-tag invalidate leaves the line as it was
    assert_foreign_tag_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (inv_en && !(fill_en && fill_idx == inv_idx) && tag_q[inv_idx] != inv_tag)
        |=> valid_q[$past(inv_idx)] == $past(valid_q[inv_idx]));

endmodule

// File: rtl/coh_barrier_ctl.sv
module coh_barrier_ctl #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bar_req,
    input  logic [CW-1:0] q_count,
    input  logic          deq,
    output logic          force_drain,
    output logic          bar_done
);
    import coh_probe_pkg::*;

    bar_state_e    state_q;
    logic [CW-1:0] rem_q;

    assign force_drain = (state_q == BAR_WAIT) && (rem_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= BAR_IDLE;
            rem_q    <= '0;
            bar_done <= 1'b0;
        end else begin
            bar_done <= 1'b0;
            unique case (state_q)
                BAR_IDLE: if (bar_req) begin
                    state_q <= BAR_WAIT;
                    rem_q   <= q_count - (deq ? CW'(1) : CW'(0));
                end
                BAR_WAIT: if (rem_q == '0) begin
                    state_q  <= BAR_IDLE;
                    bar_done <= 1'b1;
                end else if (deq) begin
                    rem_q <= rem_q - 1'b1;
                end
                default: state_q <= BAR_IDLE;
            endcase
        end
    end

    // R7: the probes a barrier waits on are always a subset of those queued
    assert_rem_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == BAR_WAIT) |-> (rem_q <= q_count));
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        bar_done |=> !bar_done);

endmodule

// File: rtl/coh_probe_inbox.sv
module coh_probe_inbox #(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int LINES     = 16,
    parameter int QDEPTH    = 8,
    parameter int DRAIN_GAP = 3,
    localparam int IDX_W    = $clog2(LINES),
    localparam int TAG_W    = AW - IDX_W,
    localparam int CW       = $clog2(QDEPTH + 1),
    localparam int GW       = $clog2(DRAIN_GAP + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prb_valid,
    input  logic [AW-1:0] prb_addr,
    output logic          prb_ready,
    output logic          prb_ack,
    input  logic          rpl_valid,
    input  logic [AW-1:0] rpl_addr,
    input  logic [DW-1:0] rpl_data,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_rsp_valid,
    output logic          ld_hit,
    output logic [DW-1:0] ld_data,
    input  logic          bar_req,
    output logic          bar_done
);
    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
    } line_addr_t;

    line_addr_t    head, rpl_line, ld_line;
    logic          push, deq, q_empty, q_full, force_drain, bg_slot, bg_ok;
    logic [AW-1:0] head_raw;
    logic [CW-1:0] q_count;

    assign head     = line_addr_t'(head_raw);
    assign rpl_line = line_addr_t'(rpl_addr);
    assign ld_line  = line_addr_t'(ld_addr);

    assign prb_ready = !q_full;
    assign push      = prb_valid && !q_full;

    always_ff @(posedge clk) begin
        if (rst) prb_ack <= 1'b0;
        else     prb_ack <= push;
    end

    // background drain pacing
    if (DRAIN_GAP == 0) begin : g_no_gap
        assign bg_slot = 1'b1;
    end else begin : g_gap
        logic [GW-1:0] gap_q;
        always_ff @(posedge clk) begin
            if (rst)                gap_q <= GW'(DRAIN_GAP);
            else if (deq)           gap_q <= GW'(DRAIN_GAP);
            else if (gap_q != '0)   gap_q <= gap_q - 1'b1;
        end
        assign bg_slot = (gap_q == '0);
    end

    assign bg_ok = bg_slot && !ld_valid && !rpl_valid;
    assign deq   = !q_empty && (force_drain || bg_ok);

    coh_probe_fifo #(.AW(AW), .DEPTH(QDEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push(push), .push_addr(prb_addr),
        .pop(deq), .head_addr(head_raw),
        .empty(q_empty), .full(q_full), .count(q_count)
    );

    coh_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DW(DW)) u_store (
        .clk(clk), .rst(rst),
        .rd_en(ld_valid), .rd_idx(ld_line.idx), .rd_tag(ld_line.tag),
        .rsp_valid(ld_rsp_valid), .rsp_hit(ld_hit), .rsp_data(ld_data),
        .fill_en(rpl_valid), .fill_idx(rpl_line.idx), .fill_tag(rpl_line.tag),
        .fill_data(rpl_data),
        .inv_en(deq), .inv_idx(head.idx), .inv_tag(head.tag)
    );

    coh_barrier_ctl #(.CW(CW)) u_bar (
        .clk(clk), .rst(rst),
        .bar_req(bar_req), .q_count(q_count), .deq(deq),
        .force_drain(force_drain), .bar_done(bar_done)
    );

    assert_ack_follows_R1: assert property (@(posedge clk) disable iff (rst)
        (prb_valid && prb_ready) |=> prb_ack);
    assert_full_no_ack_R1: assert property (@(posedge clk) disable iff (rst)
        !prb_ready |=> !prb_ack);
    assert_bg_yields_R5: assert property (@(posedge clk) disable iff (rst)
        (deq && !force_drain) |-> (!ld_valid && !rpl_valid));

endmodule

// File: tb/test_coh_probe_inbox.sv
module test_coh_probe_inbox;
    localparam int AW = 8, DW = 16;

    logic          clk = 1'b0, rst = 1'b1;
    logic          prb_valid = 0, rpl_valid = 0, ld_valid = 0, bar_req = 0;
    logic [AW-1:0] prb_addr = '0, rpl_addr = '0, ld_addr = '0;
    logic [DW-1:0] rpl_data = '0;
    logic          prb_ready, prb_ack, ld_rsp_valid, ld_hit, bar_done;
    logic [DW-1:0] ld_data;
    int checks = 0, errors = 0, cyc = 0;

    always #4 clk = ~clk;

    coh_probe_inbox #(.AW(AW), .DW(DW), .LINES(8), .QDEPTH(4), .DRAIN_GAP(600)) i_coh_probe_inbox (
        .clk(clk), .rst(rst),
        .prb_valid(prb_valid), .prb_addr(prb_addr), .prb_ready(prb_ready), .prb_ack(prb_ack),
        .rpl_valid(rpl_valid), .rpl_addr(rpl_addr), .rpl_data(rpl_data),
        .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_rsp_valid(ld_rsp_valid), .ld_hit(ld_hit), .ld_data(ld_data),
        .bar_req(bar_req), .bar_done(bar_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fill(input logic [AW-1:0] a, input logic [DW-1:0] d);
        rpl_valid = 1; rpl_addr = a; rpl_data = d;
        tick();
        rpl_valid = 0;
    endtask

    task automatic probe(input logic [AW-1:0] a);
        check(prb_ready == 1'b1, "R1 ready", int'(prb_ready), 1);
        prb_valid = 1; prb_addr = a;
        tick();
        prb_valid = 0;
        check(prb_ack == 1'b1, "R1 ack", int'(prb_ack), 1);
    endtask

    task automatic load(input logic [AW-1:0] a, input bit hit, input logic [DW-1:0] d, input string req);
        ld_valid = 1; ld_addr = a;
        tick();
        ld_valid = 0;
        check(ld_rsp_valid == 1'b1, req, int'(ld_rsp_valid), 1);
        check(ld_hit == hit, req, int'(ld_hit), int'(hit));
        if (hit) check(ld_data == d, req, int'(ld_data), int'(d));
    endtask

    task automatic barrier(input int exp_ticks, input string req);
        int n = 0;
        bar_req = 1;
        tick();
        bar_req = 0;
        for (int k = 0; k < 40; k++) begin
            tick();
            n++;
            if (bar_done) break;
        end
        check(n == exp_ticks, req, n, exp_ticks);
    endtask

    task automatic t_reset();
        check(prb_ready == 1'b1, "R10 ready", int'(prb_ready), 1);
        check(prb_ack == 1'b0, "R10 ack", int'(prb_ack), 0);
        check(bar_done == 1'b0, "R10 done", int'(bar_done), 0);
        load(8'h0A, 0, '0, "R10 lines invalid");
        barrier(1, "R10 empty queue barrier");
    endtask

    task automatic t_overtake();
        fill(8'h0A, 16'h1111);
        probe(8'h0A);
        fill(8'h0B, 16'h2222);
        load(8'h0B, 1, 16'h2222, "R2 reply overtakes queue");
        load(8'h0A, 1, 16'h1111, "R3 stale hit while queued");
        barrier(2, "R6 one pending");
        load(8'h0A, 0, '0, "R6 applied after barrier");
    endtask

    task automatic t_order();
        fill(8'h0A, 16'hA0A0);
        fill(8'h0C, 16'hC0C0);
        probe(8'h0A);
        probe(8'h0C);
        bar_req = 1;
        tick();
        bar_req = 0;
        tick();
        ld_valid = 1; ld_addr = 8'h0A;
        tick();
        ld_valid = 0;
        check(ld_hit == 1'b0, "R4 first probe applied first", int'(ld_hit), 0);
        check(bar_done == 1'b0, "R6 not yet done", int'(bar_done), 0);
        tick();
        check(bar_done == 1'b1, "R6 done at P+1", int'(bar_done), 1);
        tick();
        check(bar_done == 1'b0, "R6 single pulse", int'(bar_done), 0);
    endtask

    task automatic t_full();
        probe(8'h31);
        probe(8'h32);
        probe(8'h33);
        probe(8'h34);
        check(prb_ready == 1'b0, "R1 full", int'(prb_ready), 0);
        prb_valid = 1; prb_addr = 8'h35;
        tick();
        prb_valid = 0;
        check(prb_ack == 1'b0, "R1 no ack when full", int'(prb_ack), 0);
        barrier(5, "R6 four pending");
        check(prb_ready == 1'b1, "R1 space after drain", int'(prb_ready), 1);
    endtask

    task automatic t_mismatch();
        fill(8'h0A, 16'h3333);
        probe(8'h12);
        barrier(2, "R8 barrier");
        load(8'h0A, 1, 16'h3333, "R8 foreign tag ignored");
    endtask

    task automatic t_collide();
        probe(8'h1A);
        bar_req = 1;
        tick();
        bar_req = 0;
        rpl_valid = 1; rpl_addr = 8'h1A; rpl_data = 16'h4444;
        tick();
        rpl_valid = 0;
        tick();
        check(bar_done == 1'b1, "R9 barrier done", int'(bar_done), 1);
        load(8'h1A, 0, '0, "R9 fill then matching invalidate");
        probe(8'h22);
        bar_req = 1;
        tick();
        bar_req = 0;
        rpl_valid = 1; rpl_addr = 8'h1A; rpl_data = 16'h5555;
        tick();
        rpl_valid = 0;
        tick();
        load(8'h1A, 1, 16'h5555, "R9 fill kept on foreign tag");
    endtask

    task automatic t_late();
        fill(8'h0A, 16'h6666);
        fill(8'h0B, 16'h7777);
        probe(8'h0A);
        bar_req = 1;
        tick();
        bar_req = 0;
        prb_valid = 1; prb_addr = 8'h0B;
        tick();
        prb_valid = 0;
        check(prb_ack == 1'b1, "R7 late probe acked", int'(prb_ack), 1);
        tick();
        check(bar_done == 1'b1, "R7 late probe not waited on", int'(bar_done), 1);
        load(8'h0B, 1, 16'h7777, "R7 late probe still queued");
        load(8'h0A, 0, '0, "R7 early probe applied");
        barrier(2, "R7 second barrier");
        load(8'h0B, 0, '0, "R7 late probe applied later");
    endtask

    task automatic t_background();
        fill(8'h0D, 16'h8888);
        probe(8'h0D);
        repeat (100) tick();
        load(8'h0D, 1, 16'h8888, "R5 held before gap");
        repeat (600) tick();
        load(8'h0D, 0, '0, "R5 drained after gap");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_overtake();
        t_order();
        t_full();
        t_mismatch();
        t_collide();
        t_late();
        t_background();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule